// File: doc/BRIEF.md
# Power Management Interrupt Register File

This block is the byte-addressed register file behind a chipset's power-management function. Firmware and the operating system reach it through one byte-wide write port and one combinational read port that share an 8-bit offset. It holds status bits that hardware events set and that software clears by writing ones. It also holds enable and control registers, which take only the bits their masks allow. From this state it drives a system-control interrupt (SCI) level and a system-management interrupt (SMI).

An SMI can be requested in three ways: a write to the command byte, a global-release bit in the power control register, or a general-purpose event whose SMI enable is set. A request is accepted only while the SMI enable bit in global control is set. When the lock bit is set, a request is also refused while an earlier SMI is still marked active. Each accepted request sets an active flag, which stays set until software clears it, and gives a one-cycle strobe. Two release bits link the domains. Firmware's release bit sets a status bit on the SCI side, and the operating system's release bit sets a status bit on the SMI side.

Top module: `pm_smi_regs`

## Requirements
- R1: After reset every register, the active flag, the strobe and the SCI are zero, and a read of any offset returns 0x00. Offsets that no register uses always read 0x00.
- R2: Power status (offsets 0x00 low byte, 0x01 high byte) has writable-to-clear mask 0x8D31. A write clears each masked bit that is written as 1. Each masked bit of pm_evt sets its bit, and a set wins over a clear in the same cycle.
- R3: The masked registers read back exactly what was written ANDed with their mask: resume enable at 0x02/0x03 (mask 0x0521), power control at 0x04/0x05 (mask 0x3C07), general-purpose SCI enable at 0x22/0x23 and SMI enable at 0x24/0x25 (mask 0x03FF), and global enable at 0x2A/0x2B (mask 0x007F). In each pair the lower offset holds the low byte.
- R4: sci is high in the cycle after the state changes if any bit is set in both power status and resume enable, or in both general-purpose status and general-purpose SCI enable.
- R5: A write to 0x04 with data bit 2 set sets global status bit 5. If global enable bit 5 is set, it also requests an SMI.
- R6: A write to 0x2F stores the command byte, which reads back at 0x2F, and sets global status bit 6. If global enable bit 6 is set, it also requests an SMI.
- R7: Global status (0x28/0x29, mask 0x007F) and general-purpose status (0x20/0x21, mask 0x03FF) are cleared by writing ones. Each bit of gp_evt sets the matching general-purpose status bit.
- R8: A request is accepted only if global control bit 0 is set and either the lock (global control bit 4) is clear or smi_active is low. An accepted request sets smi_active and raises smi_strobe for exactly the cycle that follows. A refused request changes neither output.
- R9: A write to 0x2C stores the global control low byte. If data bit 1 is set, it also sets power status bit 5. A read of 0x2C returns the stored byte with bit 4 replaced by the lock and bit 0 replaced by smi_active.
- R10: A write to 0x2D with data bit 0 set clears smi_active. A request accepted in the same cycle wins.
- R11: After any write to 0x00 that leaves power status bit 5 clear, global control bit 1 reads as 0.
- R12: A gp_evt bit whose general-purpose SMI enable bit is set requests an SMI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for one byte |
| addr | input | 8 | Byte offset for reads and writes |
| wdata | input | 8 | Write data |
| pm_evt | input | 16 | Event pulses that set power status bits |
| gp_evt | input | GP_BITS | Event pulses that set general-purpose status bits |
| rdata | output | 8 | Combinational read data at addr |
| sci | output | 1 | System-control interrupt level |
| smi_active | output | 1 | SMI in progress, held until software clears it |
| smi_strobe | output | 1 | One-cycle pulse for each accepted SMI request |

## Verification
A corrupted status or enable bit shows on rdata as soon as its offset is read, and on sci in the same cycle when the matching enable is set. A wrong active flag or lock decision shows in the cycle right after the triggering write. The strobe appears or stays low there, and the active bit in the 0x2C readback changes there too. Stale cross-domain release effects show on the next read of power status, global status or global control.

// File: rtl/pm_smi_pkg.sv
// Package: offsets, masks and bit positions shared by the power-management
// register file. Assumes one byte is accessed per cycle.
package pm_smi_pkg;
    localparam int LANE_W = 8;
    localparam int REG_W  = 16;

    // Offsets of the register pairs (low byte at the even offset)
    localparam logic [7:0] OFS_PSTS  = 8'h00;
    localparam logic [7:0] OFS_PEN   = 8'h02;
    localparam logic [7:0] OFS_PCTL  = 8'h04;
    localparam logic [7:0] OFS_GPSTS = 8'h20;
    localparam logic [7:0] OFS_GPSCI = 8'h22;
    localparam logic [7:0] OFS_GPSMI = 8'h24;
    localparam logic [7:0] OFS_GSTS  = 8'h28;
    localparam logic [7:0] OFS_GEN   = 8'h2A;
    localparam logic [7:0] OFS_GCTL  = 8'h2C;
    localparam logic [7:0] OFS_GCTH  = 8'h2D;
    localparam logic [7:0] OFS_CMD   = 8'h2F;

    // Write masks
    localparam logic [15:0] MASK_PSTS = 16'h8D31;
    localparam logic [15:0] MASK_PEN  = 16'h0521;
    localparam logic [15:0] MASK_PCTL = 16'h3C07;
    localparam logic [15:0] MASK_GLB  = 16'h007F;

    // Bit positions the behaviour depends on
    localparam int PCTL_RELEASE = 2;
    localparam int GSTS_RELEASE = 5;
    localparam int GSTS_CMD     = 6;
    localparam int PSTS_FWREL   = 5;
    localparam int GCTL_SMIEN   = 0;
    localparam int GCTL_FWREL   = 1;
    localparam int GCTL_LOCK    = 4;
    localparam int GCTH_CLRACT  = 0;
endpackage

// File: rtl/pm_mask_reg.sv
// Module: byte-lane writable register whose bits outside MASK stay zero.
// Assumes at most one lane is written per cycle; reset clears all bits.
module pm_mask_reg #(
    parameter int          W    = 16,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W/8-1:0]   wr_lane,
    input  logic [7:0]       wdata,
    output logic [W-1:0]     q
);
    localparam int NB = W / 8;

    for (genvar i = 0; i < NB; i++) begin : g_lane
        // Store the masked write data of one byte lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i*8 +: 8] <= '0;
            else if (wr_lane[i])
                q[i*8 +: 8] <= wdata & MASK[i*8 +: 8];
        end

        assert_mask_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
            wr_lane[i] |=> q[i*8 +: 8] == ($past(wdata) & MASK[i*8 +: 8]));
    end
endmodule

// File: rtl/pm_w1c_reg.sv
// Module: status register that hardware sets and software clears by writing
// ones to a byte lane. Masked bits only. A set beats a clear in one cycle.
module pm_w1c_reg #(
    parameter int          W    = 16,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W/8-1:0]   wr_lane,
    input  logic [7:0]       wdata,
    input  logic [W-1:0]     set_vec,
    output logic [W-1:0]     q,
    output logic [W-1:0]     q_nxt
);
    localparam int NB = W / 8;

    logic [W-1:0] clr_vec;

    for (genvar i = 0; i < NB; i++) begin : g_clr
        // Spread the written ones of a lane into the clear vector
        always_comb clr_vec[i*8 +: 8] = wr_lane[i] ? (wdata & MASK[i*8 +: 8]) : 8'h00;
    end

    // Next state: clear the written ones, then apply hardware sets
    always_comb q_nxt = (q & ~clr_vec) | (set_vec & MASK);

    // Hold the status bits
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else
            q <= q_nxt;
    end

    assert_set_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_vec & MASK)) |=> ((q & $past(set_vec & MASK)) == $past(set_vec & MASK)));

    assert_clear_works_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((|wr_lane) && (set_vec == '0)) |=> ((q & $past(clr_vec)) == '0));
endmodule

// File: rtl/pm_smi_ctrl.sv
// Module: SMI acceptance unit. Accepts a request when SMI is enabled and the
// lock does not block it; holds the active flag and gives a one-cycle strobe.
module pm_smi_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic smi_en,
    input  logic lock,
    input  logic clr_active,
    output logic active,
    output logic strobe
);
    logic accept;

    // Acceptance decision from the current enable, lock and active state
    always_comb accept = req && smi_en && (!lock || !active);

    // Active flag and strobe; an acceptance wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            strobe <= 1'b0;
        end else begin
            strobe <= accept;
            if (accept)
                active <= 1'b1;
            else if (clr_active)
                active <= 1'b0;
        end
    end

    assert_lock_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && lock && active) |=> !strobe);
    assert_disabled_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !smi_en) |=> !strobe);
    assert_strobe_marks_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> active);
    assert_clear_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_active && !req) |=> !active);
endmodule

// File: rtl/pm_smi_regs.sv
// Module: power-management register file. Decodes byte writes into status,
// enable and control registers, routes events to SCI and SMI, and serves a
// combinational byte read. Assumes one access per cycle, reset synchronous.
module pm_smi_regs #(
    parameter int GP_BITS = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [7:0]         addr,
    input  logic [7:0]         wdata,
    input  logic [15:0]        pm_evt,
    input  logic [GP_BITS-1:0] gp_evt,
    output logic [7:0]         rdata,
    output logic               sci,
    output logic               smi_active,
    output logic               smi_strobe
);
    import pm_smi_pkg::*;

    localparam logic [15:0] MASK_GP = 16'((32'd1 << GP_BITS) - 1);

    logic [15:0] psts, psts_nxt, pen, pctl, gpsts, gpsts_nxt, gpsci, gpsmi;
    logic [15:0] gsts, gsts_nxt, gen;
    logic [15:0] psts_set, gsts_set, gp_set;
    logic [7:0]  gctl, cmd, gctl_rd;
    logic        wr_psts_lo, wr_pctl_lo, wr_gctl, wr_gcth, wr_cmd;
    logic        fw_release, os_release, smi_req;

    // Decode the single-byte writes that carry side effects
    always_comb begin
        wr_psts_lo = wr_en && (addr == OFS_PSTS);
        wr_pctl_lo = wr_en && (addr == OFS_PCTL);
        wr_gctl    = wr_en && (addr == OFS_GCTL);
        wr_gcth    = wr_en && (addr == OFS_GCTH);
        wr_cmd     = wr_en && (addr == OFS_CMD);
        fw_release = wr_gctl && wdata[GCTL_FWREL];
        os_release = wr_pctl_lo && wdata[PCTL_RELEASE];
    end

    // Lane enable for a 16-bit register pair at an even offset
    function automatic logic [1:0] lanes(input logic we, input logic [7:0] a,
                                         input logic [7:0] base);
        return {we && (a == (base | 8'h01)), we && (a == base)};
    endfunction

    // Hardware set vectors for the three status registers
    always_comb begin
        psts_set = pm_evt;
        psts_set[PSTS_FWREL] = pm_evt[PSTS_FWREL] | fw_release;
        gsts_set = '0;
        gsts_set[GSTS_RELEASE] = os_release;
        gsts_set[GSTS_CMD]     = wr_cmd;
        gp_set = 16'(gp_evt);
    end

    pm_w1c_reg #(.W(16), .MASK(MASK_PSTS)) u_psts (
        .clk(clk), .rst_n(rst_n), .wr_lane(lanes(wr_en, addr, OFS_PSTS)),
        .wdata(wdata), .set_vec(psts_set), .q(psts), .q_nxt(psts_nxt));

    pm_w1c_reg #(.W(16), .MASK(MASK_GP)) u_gpsts (
        .clk(clk), .rst_n(rst_n), .wr_lane(lanes(wr_en, addr, OFS_GPSTS)),
        .wdata(wdata), .set_vec(gp_set), .q(gpsts), .q_nxt(gpsts_nxt));

    pm_w1c_reg #(.W(16), .MASK(MASK_GLB)) u_gsts (
        .clk(clk), .rst_n(rst_n), .wr_lane(lanes(wr_en, addr, OFS_GSTS)),
        .wdata(wdata), .set_vec(gsts_set), .q(gsts), .q_nxt(gsts_nxt));

    pm_mask_reg #(.W(16), .MASK(MASK_PEN)) u_pen (
        .clk(clk), .rst_n(rst_n), .wr_lane(lanes(wr_en, addr, OFS_PEN)),
        .wdata(wdata), .q(pen));

    pm_mask_reg #(.W(16), .MASK(MASK_PCTL)) u_pctl (
        .clk(clk), .rst_n(rst_n), .wr_lane(lanes(wr_en, addr, OFS_PCTL)),
        .wdata(wdata), .q(pctl));

    pm_mask_reg #(.W(16), .MASK(MASK_GP)) u_gpsci (
        .clk(clk), .rst_n(rst_n), .wr_lane(lanes(wr_en, addr, OFS_GPSCI)),
        .wdata(wdata), .q(gpsci));

    pm_mask_reg #(.W(16), .MASK(MASK_GP)) u_gpsmi (
        .clk(clk), .rst_n(rst_n), .wr_lane(lanes(wr_en, addr, OFS_GPSMI)),
        .wdata(wdata), .q(gpsmi));

    pm_mask_reg #(.W(16), .MASK(MASK_GLB)) u_gen (
        .clk(clk), .rst_n(rst_n), .wr_lane(lanes(wr_en, addr, OFS_GEN)),
        .wdata(wdata), .q(gen));

    // Global control low byte; firmware-release bit drops when status bit 5 is cleared
    always_ff @(posedge clk) begin
        if (!rst_n)
            gctl <= 8'h00;
        else if (wr_gctl)
            gctl <= wdata;
        else if (wr_psts_lo && !psts_nxt[PSTS_FWREL])
            gctl[GCTL_FWREL] <= 1'b0;
    end

    // SMI command byte
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd <= 8'h00;
        else if (wr_cmd)
            cmd <= wdata;
    end

    // Collect every SMI request source of this cycle
    always_comb smi_req = (os_release && gen[GSTS_RELEASE])
                        || (wr_cmd && gen[GSTS_CMD])
                        || (|(gp_set & gpsmi));

    pm_smi_ctrl u_smi (
        .clk(clk), .rst_n(rst_n), .req(smi_req),
        .smi_en(gctl[GCTL_SMIEN]), .lock(gctl[GCTL_LOCK]),
        .clr_active(wr_gcth && wdata[GCTH_CLRACT]),
        .active(smi_active), .strobe(smi_strobe));

    // SCI level from enabled status
    always_comb sci = (|(psts & pen)) || (|(gpsts & gpsci));

    // Global control readback with lock and active substituted
    always_comb begin
        gctl_rd = gctl;
        gctl_rd[GCTL_LOCK]  = gctl[GCTL_LOCK];
        gctl_rd[GCTL_SMIEN] = smi_active;
    end

    // Byte read multiplexer
    always_comb begin
        case (addr[7:1])
            OFS_PSTS[7:1]:  rdata = addr[0] ? psts[15:8]  : psts[7:0];
            OFS_PEN[7:1]:   rdata = addr[0] ? pen[15:8]   : pen[7:0];
            OFS_PCTL[7:1]:  rdata = addr[0] ? pctl[15:8]  : pctl[7:0];
            OFS_GPSTS[7:1]: rdata = addr[0] ? gpsts[15:8] : gpsts[7:0];
            OFS_GPSCI[7:1]: rdata = addr[0] ? gpsci[15:8] : gpsci[7:0];
            OFS_GPSMI[7:1]: rdata = addr[0] ? gpsmi[15:8] : gpsmi[7:0];
            OFS_GSTS[7:1]:  rdata = addr[0] ? gsts[15:8]  : gsts[7:0];
            OFS_GEN[7:1]:   rdata = addr[0] ? gen[15:8]   : gen[7:0];
            OFS_GCTL[7:1]:  rdata = addr[0] ? 8'h00       : gctl_rd;
            OFS_CMD[7:1]:   rdata = addr[0] ? cmd         : 8'h00;
            default:        rdata = 8'h00;
        endcase
    end

    assert_fw_release_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fw_release |=> psts[PSTS_FWREL]);
    assert_cmd_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd |=> gsts[GSTS_CMD]);
    assert_os_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        os_release |=> gsts[GSTS_RELEASE]);
    assert_release_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_psts_lo && !psts_nxt[PSTS_FWREL]) |=> !gctl[GCTL_FWREL]);
endmodule

// File: tb/pm_smi_regs_test.sv
`timescale 1ns/1ps
// Bench: sweeps the masked registers and status bits, then walks the SMI
// lock/active handshake and the cross-domain release paths.
module pm_smi_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [7:0]  wdata = 8'h00;
    logic [15:0] pm_evt = 16'h0000;
    logic [9:0]  gp_evt = 10'h000;
    logic [7:0]  rdata;
    logic        sci, smi_active, smi_strobe;
    int checks = 0;
    int errors = 0;
    logic st;
    logic [7:0] rv;

    always #2 clk = ~clk;

    pm_smi_regs #(.GP_BITS(10)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .pm_evt(pm_evt), .gp_evt(gp_evt), .rdata(rdata), .sci(sci),
        .smi_active(smi_active), .smi_strobe(smi_strobe));

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle of stimulus; st captures the strobe in the following cycle
    task automatic cyc(input logic we, input logic [7:0] a, input logic [7:0] d,
                       input logic [15:0] pe, input logic [9:0] ge);
        @(negedge clk);
        wr_en = we; addr = a; wdata = d; pm_evt = pe; gp_evt = ge;
        @(negedge clk);
        st = smi_strobe;
        wr_en = 1'b0; pm_evt = '0; gp_evt = '0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        cyc(1'b1, a, d, 16'h0, 10'h0);
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b0; addr = a;
        #1 v = rdata;
    endtask

    task automatic rd16(input logic [7:0] a, output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(a, lo);
        rd(a | 8'h01, hi);
        v = {hi, lo};
    endtask

    // Exhaustive byte sweep of one masked pair
    task automatic sweep(input logic [7:0] base, input logic [15:0] mask, input string req);
        for (int lane = 0; lane < 2; lane++) begin
            for (int v = 0; v < 256; v++) begin
                logic [7:0] got;
                logic [7:0] m;
                m = lane ? mask[15:8] : mask[7:0];
                wr(base | 8'(lane), 8'(v));
                rd(base | 8'(lane), got);
                chk(req, {8'h0, got}, {8'h0, 8'(v) & m});
            end
            wr(base | 8'(lane), 8'h00);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [15:0] v16;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, every offset reads zero
        chk("R1 outputs", {13'h0, sci, smi_active, smi_strobe}, 16'h0);
        for (int a = 0; a < 256; a++) begin
            rd(8'(a), rv);
            chk("R1 read", {8'h0, rv}, 16'h0);
        end

        // R3: masked registers
        sweep(8'h02, 16'h0521, "R3 resume enable");
        sweep(8'h22, 16'h03FF, "R3 gp sci enable");
        sweep(8'h24, 16'h03FF, "R3 gp smi enable");
        sweep(8'h2A, 16'h007F, "R3 global enable");
        sweep(8'h04, 16'h3C07, "R3 power control");
        wr(8'h28, 8'h7F);

        // R2: each status bit cleared alone by writing one
        for (int b = 0; b < 16; b++) begin
            logic [15:0] bit1;
            bit1 = 16'h1 << b;
            cyc(1'b0, 8'h00, 8'h00, 16'hFFFF, 10'h0);
            wr(8'h00 | 8'(b / 8), 8'(bit1 >> ((b / 8) * 8)));
            rd16(8'h00, v16);
            chk("R2 clear one", v16, 16'h8D31 & ~bit1);
            wr(8'h00, 8'hFF); wr(8'h01, 8'hFF);
        end
        // R2: set wins over clear
        cyc(1'b1, 8'h00, 8'h01, 16'h0001, 10'h0);
        rd16(8'h00, v16);
        chk("R2 set beats clear", v16, 16'h0001);
        wr(8'h00, 8'h01);

        // R7: general-purpose status
        for (int b = 0; b < 10; b++) begin
            logic [15:0] bit1;
            bit1 = 16'h1 << b;
            cyc(1'b0, 8'h00, 8'h00, 16'h0, 10'h3FF);
            wr(8'h20 | 8'(b / 8), 8'(bit1 >> ((b / 8) * 8)));
            rd16(8'h20, v16);
            chk("R7 gp clear", v16, 16'h03FF & ~bit1);
            wr(8'h20, 8'hFF); wr(8'h21, 8'hFF);
        end

        // R4: SCI from power and gp domains
        wr(8'h02, 8'h01);
        cyc(1'b0, 8'h00, 8'h00, 16'h0001, 10'h0);
        chk("R4 sci power", {15'h0, sci}, 16'h1);
        wr(8'h00, 8'h01);
        chk("R4 sci drops", {15'h0, sci}, 16'h0);
        cyc(1'b0, 8'h00, 8'h00, 16'h0400, 10'h0);
        chk("R4 sci unenabled", {15'h0, sci}, 16'h0);
        wr(8'h01, 8'h04);
        wr(8'h02, 8'h00);
        wr(8'h23, 8'h02);
        cyc(1'b0, 8'h00, 8'h00, 16'h0, 10'h200);
        chk("R4 sci gp", {15'h0, sci}, 16'h1);
        wr(8'h21, 8'h02);
        chk("R4 sci gp drops", {15'h0, sci}, 16'h0);
        wr(8'h23, 8'h00);

        // R6/R8: command SMI with lock clear
        wr(8'h2A, 8'h60);
        wr(8'h2C, 8'h01);
        wr(8'h2F, 8'h5A);
        chk("R8 strobe on cmd", {15'h0, st}, 16'h1);
        chk("R8 active level", {15'h0, smi_active}, 16'h1);
        rd(8'h2F, rv); chk("R6 cmd readback", {8'h0, rv}, 16'h005A);
        rd(8'h28, rv); chk("R6 global status bit6", {8'h0, rv}, 16'h0040);
        @(negedge clk);
        chk("R8 strobe one cycle", {15'h0, smi_strobe}, 16'h0);
        wr(8'h2F, 8'h11);
        chk("R8 unlocked re-raise", {15'h0, st}, 16'h1);

        // R8/R9: locked, active blocks
        wr(8'h2C, 8'h11);
        rd(8'h2C, rv); chk("R9 gctl read lock+active", {8'h0, rv}, 16'h0011);
        wr(8'h2F, 8'h22);
        chk("R8 lock blocks", {15'h0, st}, 16'h0);
        // R10: clear active
        wr(8'h2D, 8'h01);
        chk("R10 active cleared", {15'h0, smi_active}, 16'h0);
        rd(8'h2C, rv); chk("R9 gctl read cleared", {8'h0, rv}, 16'h0010);
        wr(8'h2F, 8'h33);
        chk("R8 accept after clear", {15'h0, st}, 16'h1);
        wr(8'h2D, 8'h00);
        chk("R10 bit0 zero keeps active", {15'h0, smi_active}, 16'h1);

        // R5: release path
        wr(8'h28, 8'h7F);
        wr(8'h04, 8'h04);
        chk("R5 locked release blocked", {15'h0, st}, 16'h0);
        rd(8'h28, rv); chk("R5 status bit5", {8'h0, rv}, 16'h0020);
        wr(8'h2D, 8'h01);
        wr(8'h04, 8'h04);
        chk("R5 release raises SMI", {15'h0, st}, 16'h1);
        wr(8'h2A, 8'h00);
        wr(8'h2D, 8'h01);
        wr(8'h04, 8'h04);
        chk("R5 release unenabled", {15'h0, st}, 16'h0);
        wr(8'h04, 8'h00);

        // R8: SMI enable clear
        wr(8'h2A, 8'h40);
        wr(8'h2C, 8'h00);
        wr(8'h2F, 8'h44);
        chk("R8 disabled no strobe", {15'h0, st}, 16'h0);
        chk("R8 disabled no active", {15'h0, smi_active}, 16'h0);

        // R12: gp event SMI
        wr(8'h2C, 8'h01);
        wr(8'h25, 8'h02);
        cyc(1'b0, 8'h00, 8'h00, 16'h0, 10'h100);
        chk("R12 unenabled gp", {15'h0, st}, 16'h0);
        cyc(1'b0, 8'h00, 8'h00, 16'h0, 10'h200);
        chk("R12 gp smi", {15'h0, st}, 16'h1);
        wr(8'h2D, 8'h01);

        // R9/R11: firmware release to SCI side
        wr(8'h02, 8'h20);
        chk("R9 sci before", {15'h0, sci}, 16'h0);
        wr(8'h2C, 8'h02);
        chk("R9 sci raised", {15'h0, sci}, 16'h1);
        rd16(8'h00, v16); chk("R9 status bit5", v16 & 16'h0020, 16'h0020);
        rd(8'h2C, rv); chk("R9 gctl bit1 held", {8'h0, rv}, 16'h0002);
        wr(8'h00, 8'h01);
        rd(8'h2C, rv); chk("R11 bit1 kept while status set", {8'h0, rv}, 16'h0002);
        wr(8'h00, 8'h20);
        rd(8'h2C, rv); chk("R11 bit1 dropped", {8'h0, rv}, 16'h0000);
        chk("R9 sci cleared", {15'h0, sci}, 16'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule